// File: doc/BRIEF.md
# Programmable Sum-of-Products Macrocell

This block is one logic cell of the kind found in a complex programmable logic device. Six literal inputs, each in true and complemented form, feed a programmable AND plane of eight product terms. An OR gate sums any chosen subset of those terms together with two side inputs that bypass the AND plane entirely. A D flip-flop samples the sum on every clock. A configuration bit picks either the flip-flop or the raw sum as the one output of the cell.

All programming lives in a 107-bit shift register that loads serially, one bit per clock, while `cfg_en` is high. The chain has a serial output, so several cells can share one configuration stream. A typical use: clear the cell with reset, shift in a pattern, release `cfg_en`, then drive literals and side inputs. One example pattern is `f = a·b + b·c' + g + h`, with a, b, c on literals 0, 1, 2 and g, h on side inputs 0, 1.

Top module: `mc_macrocell`

## Requirements
- R1: Term p is the AND of its enabled literal checks. True-enable of literal i sits at chain bit 12p+2i and requires `lit_in[i]`=1. Complement-enable sits at bit 12p+2i+1 and requires `lit_in[i]`=0. A term with no enable bit set is 0.
- R2: A term that enables both the true and the complement form of the same literal is always 0.
- R3: The combinational sum is 1 exactly when an OR-enabled term is 1 or an enabled side input is 1. Term p is OR-enabled by chain bit 96+p, and side input e by bit 104+e. Terms and side inputs that are not enabled have no effect.
- R4: The flip-flop takes the sum on every rising clock edge. `rst` is synchronous: a high `rst` clears the flip-flop at the next edge and not before.
- R5: Chain bit 106 selects the output. A 1 drives `cell_out` from the flip-flop; a 0 drives it from the combinational sum.
- R6: On each rising edge with `cfg_en` high, `cfg_sdi` enters at bit 106 and every bit moves one place toward bit 0. After 107 shifts, the first bit sent sits at bit 0. With `cfg_en` low the chain holds its contents.
- R7: `cfg_sdo` always shows chain bit 0, so a reload streams out the previous pattern, bit 0 first.
- R8: Reset clears the whole chain and the flip-flop. After reset `cell_out` is 0 and `cfg_sdo` is 0.
- R9: In registered mode `cell_out` trails the value the bypass path would show by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for chain and flip-flop |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_sdi | input | 1 | Serial configuration data in |
| cfg_sdo | output | 1 | Serial configuration data out (chain bit 0) |
| lit_in | input | 6 | Literal inputs to the AND plane |
| ext_in | input | 2 | Side inputs routed straight to the OR gate |
| cell_out | output | 1 | Cell output, registered or combinational |

## Verification
The assertions check four things on every clock. Chain movement is checked both while shifting and while holding. The flip-flop must take the previous sum, and reset must clear it. Empty and self-contradicting terms must stay at 0, the sum must stay at 0 when nothing enabled is high, and the registered output must trail the sum by one cycle.

Other behaviour only the bench's scenarios can show, because only they know what the cell was programmed to compute. These are the full truth table of the example function in both output modes, and that disabled terms and side inputs have no effect. They also cover the exact bit order of the chain, as seen through `cfg_sdo` on reload, and that reset takes effect at the clock edge and not before it.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic {
    MODE_COMB = 1'b0,
    MODE_REG  = 1'b1
  } out_mode_e;

  // Chain length: per-term literal enables, per-term OR enables,
  // side-input enables, output mode bit.
  function automatic int cfg_bits(input int nl, input int np, input int ne);
    return np * 2 * nl + np + ne + 1;
  endfunction

endpackage

// File: rtl/mc_scan_chain.sv
module mc_scan_chain #(
  parameter int W = 107
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         sdi,
  output logic         sdo,
  output logic [W-1:0] bits
);

  always_ff @(posedge clk) begin
    if (rst)
      bits <= '0;
    else if (shift_en)
      bits <= {sdi, bits[W-1:1]};
  end

  assign sdo = bits[0];

endmodule

// File: rtl/mc_and_plane.sv
module mc_and_plane #(
  parameter int NL = 6,
  parameter int NP = 8
) (
  input  logic [NL-1:0]      lit,
  input  logic [NP*2*NL-1:0] mask,
  output logic [NP-1:0]      pt
);

  localparam int TERM_W = 2 * NL;

  for (genvar p = 0; p < NP; p++) begin : g_term
    logic [NL-1:0] t_en;
    logic [NL-1:0] c_en;
    for (genvar i = 0; i < NL; i++) begin : g_lit
      assign t_en[i] = mask[p*TERM_W + 2*i];
      assign c_en[i] = mask[p*TERM_W + 2*i + 1];
    end
    // Empty term forced low; both polarities of a literal cancel out.
    assign pt[p] = (|(t_en | c_en)) && (&((~t_en | lit) & (~c_en | ~lit)));
  end

endmodule

// File: rtl/mc_or_plane.sv
module mc_or_plane #(
  parameter int NP = 8,
  parameter int NE = 2
) (
  input  logic [NP-1:0] pt,
  input  logic [NP-1:0] pt_en,
  input  logic [NE-1:0] ext,
  input  logic [NE-1:0] ext_en,
  output logic          sum
);

  assign sum = (|(pt & pt_en)) | (|(ext & ext_en));

endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
  import mc_pkg::*;
#(
  parameter int N_LIT = 6,
  parameter int N_PT  = 8,
  parameter int N_EXT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_sdi,
  output logic             cfg_sdo,
  input  logic [N_LIT-1:0] lit_in,
  input  logic [N_EXT-1:0] ext_in,
  output logic             cell_out
);

  localparam int AND_BITS = N_PT * 2 * N_LIT;
  localparam int CFG_W    = cfg_bits(N_LIT, N_PT, N_EXT);
  localparam int PTEN_LSB = AND_BITS;
  localparam int EXT_LSB  = AND_BITS + N_PT;
  localparam int MODE_BIT = CFG_W - 1;

  logic [CFG_W-1:0]    cfg_q;
  logic [AND_BITS-1:0] and_mask;
  logic [N_PT-1:0]     pt_en;
  logic [N_EXT-1:0]    ext_en;
  logic [N_PT-1:0]     pt_w;
  logic                sum_w;
  logic                q_r;
  out_mode_e           out_mode;
  logic                out_reg;

  mc_scan_chain #(.W(CFG_W)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_en),
    .sdi      (cfg_sdi),
    .sdo      (cfg_sdo),
    .bits     (cfg_q)
  );

  assign and_mask = cfg_q[AND_BITS-1:0];
  assign pt_en    = cfg_q[PTEN_LSB +: N_PT];
  assign ext_en   = cfg_q[EXT_LSB +: N_EXT];
  assign out_mode = out_mode_e'(cfg_q[MODE_BIT]);
  assign out_reg  = (out_mode == MODE_REG);

  mc_and_plane #(.NL(N_LIT), .NP(N_PT)) u_and (
    .lit  (lit_in),
    .mask (and_mask),
    .pt   (pt_w)
  );

  mc_or_plane #(.NP(N_PT), .NE(N_EXT)) u_or (
    .pt     (pt_w),
    .pt_en  (pt_en),
    .ext    (ext_in),
    .ext_en (ext_en),
    .sum    (sum_w)
  );

  always_ff @(posedge clk) begin
    if (rst) q_r <= 1'b0;
    else     q_r <= sum_w;
  end

  assign cell_out = out_reg ? q_r : sum_w;

endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk #(
  parameter int NL = 6,
  parameter int NP = 8,
  parameter int NE = 2,
  parameter int CW = 107
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_en,
  input logic              cfg_sdi,
  input logic [CW-1:0]     cfg_vec,
  input logic [NP*2*NL-1:0] and_mask,
  input logic [NP-1:0]     pt,
  input logic [NP-1:0]     pt_en,
  input logic [NE-1:0]     ext,
  input logic [NE-1:0]     ext_en,
  input logic              sum,
  input logic              q,
  input logic              out_reg,
  input logic              cell_out
);

  assert_shift_in_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (cfg_vec[CW-1] == $past(cfg_sdi)) &&
               (cfg_vec[CW-2:0] == $past(cfg_vec[CW-1:1])));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_vec));

  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q == $past(sum)));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!q && (cfg_vec == '0)));

  assert_reg_lag_R9: assert property (@(posedge clk) disable iff (rst)
    (out_reg && !$past(rst)) |-> (cell_out == $past(sum)));

  assert_or_masked_R3: assert property (@(posedge clk) disable iff (rst)
    (((pt & pt_en) == '0) && ((ext & ext_en) == '0)) |-> !sum);

  for (genvar p = 0; p < NP; p++) begin : g_term_chk
    logic [NL-1:0] t_en;
    logic [NL-1:0] c_en;
    for (genvar i = 0; i < NL; i++) begin : g_bit
      assign t_en[i] = and_mask[p*2*NL + 2*i];
      assign c_en[i] = and_mask[p*2*NL + 2*i + 1];
    end

    assert_empty_term_R1: assert property (@(posedge clk) disable iff (rst)
      ((t_en | c_en) == '0) |-> !pt[p]);

    assert_conflict_term_R2: assert property (@(posedge clk) disable iff (rst)
      ((t_en & c_en) != '0) |-> !pt[p]);
  end

endmodule

bind mc_macrocell mc_macrocell_chk #(
  .NL (N_LIT),
  .NP (N_PT),
  .NE (N_EXT),
  .CW (CFG_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_en   (cfg_en),
  .cfg_sdi  (cfg_sdi),
  .cfg_vec  (cfg_q),
  .and_mask (and_mask),
  .pt       (pt_w),
  .pt_en    (pt_en),
  .ext      (ext_in),
  .ext_en   (ext_en),
  .sum      (sum_w),
  .q        (q_r),
  .out_reg  (out_reg),
  .cell_out (cell_out)
);

// File: tb/mc_macrocell_tb.sv
module mc_macrocell_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NL    = 6;
  localparam int NP    = 8;
  localparam int NE    = 2;
  localparam int AB    = NP * 2 * NL;
  localparam int CW    = AB + NP + NE + 1;
  localparam int PTEN  = AB;
  localparam int EXTEN = AB + NP;
  localparam int MODEB = CW - 1;
  localparam int NVEC  = 12;

  // Entry = {ext[1:0], lit[5:0], expected} for f = a.b + b.c' + g + h
  localparam logic [8:0] VEC [NVEC] = '{
    9'b00_000000_0, 9'b00_000011_1, 9'b00_000010_1, 9'b00_000110_0,
    9'b00_000111_1, 9'b00_000101_0, 9'b01_000000_1, 9'b10_000000_1,
    9'b00_111000_0, 9'b00_111110_0, 9'b11_000100_1, 9'b00_111111_1
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_en = 1'b0;
  logic          cfg_sdi = 1'b0;
  logic          cfg_sdo;
  logic [NL-1:0] lit_in = '0;
  logic [NE-1:0] ext_in = '0;
  logic          cell_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  mc_macrocell u_dut (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .cfg_sdi  (cfg_sdi),
    .cfg_sdo  (cfg_sdo),
    .lit_in   (lit_in),
    .ext_in   (ext_in),
    .cell_out (cell_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic fspec(input logic [NL-1:0] l, input logic [NE-1:0] e,
                                 input logic g_on, input logic h_on);
    return (l[0] & l[1]) | (l[1] & ~l[2]) | (e[0] & g_on) | (e[1] & h_on);
  endfunction

  // Example pattern plus an empty term, a conflicting term and an
  // unrouted term, none of which may change f.
  function automatic logic [CW-1:0] mk_cfg(input logic reg_mode,
                                           input logic g_on, input logic h_on);
    logic [CW-1:0] v;
    v = '0;
    v[0]  = 1'b1;              // term0: a true
    v[2]  = 1'b1;              // term0: b true
    v[14] = 1'b1;              // term1: b true
    v[17] = 1'b1;              // term1: c complement
    v[36] = 1'b1;              // term3: a true
    v[37] = 1'b1;              // term3: a complement
    v[54] = 1'b1;              // term4: d true, not routed to OR
    v[PTEN+0] = 1'b1;
    v[PTEN+1] = 1'b1;
    v[PTEN+2] = 1'b1;          // term2 has no literal enabled
    v[PTEN+3] = 1'b1;
    v[EXTEN+0] = g_on;
    v[EXTEN+1] = h_on;
    v[MODEB]   = reg_mode;
    return v;
  endfunction

  task automatic load_cfg(input logic [CW-1:0] nv, input logic [CW-1:0] ov);
    for (int i = 0; i < CW; i++) begin
      @(negedge clk);
      chk("R7 sdo stream", cfg_sdo, ov[i]);
      cfg_en  = 1'b1;
      cfg_sdi = nv[i];
    end
    @(negedge clk);
    cfg_en  = 1'b0;
    cfg_sdi = 1'b0;
  endtask

  task automatic walk_comb(input string req);
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      {ext_in, lit_in} = VEC[k][8:1];
      #1;
      chk(req, cell_out, VEC[k][0]);
    end
  endtask

  logic [CW-1:0] cfg_c, cfg_g, cfg_r;
  logic [NL-1:0] pl;
  logic [NE-1:0] pe;

  initial begin
    cfg_c = mk_cfg(1'b0, 1'b1, 1'b1);
    cfg_g = mk_cfg(1'b0, 1'b1, 1'b0);
    cfg_r = mk_cfg(1'b1, 1'b1, 1'b1);

    // Reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    lit_in = 6'b000011;
    ext_in = 2'b11;
    #1;
    chk("R8 out after reset", cell_out, 1'b0);
    chk("R8 sdo after reset", cfg_sdo, 1'b0);

    // Bypass mode
    load_cfg(cfg_c, '0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cfg_sdi = i[0];
    end
    cfg_sdi = 1'b0;
    walk_comb("R6 hold then R1/R2/R3/R5 table");
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      {ext_in, lit_in} = k[7:0];
      #1;
      chk("R5 bypass exhaustive", cell_out, fspec(k[5:0], k[7:6], 1'b1, 1'b1));
    end

    // Side input h disabled
    load_cfg(cfg_g, cfg_c);
    @(negedge clk); lit_in = '0; ext_in = 2'b10; #1;
    chk("R3 disabled side input", cell_out, 1'b0);
    @(negedge clk); ext_in = 2'b01; #1;
    chk("R3 enabled side input", cell_out, 1'b1);
    @(negedge clk); lit_in = 6'b001000; ext_in = 2'b00; #1;
    chk("R3 unrouted term", cell_out, 1'b0);

    // Registered mode
    load_cfg(cfg_r, cfg_g);
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      {ext_in, lit_in} = VEC[k][8:1];
      @(posedge clk);
      #1;
      chk("R4 registered table", cell_out, VEC[k][0]);
    end
    pl = lit_in;
    pe = ext_in;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      {ext_in, lit_in} = k[7:0];
      #1;
      chk("R9 lag before edge", cell_out, fspec(pl, pe, 1'b1, 1'b1));
      @(posedge clk);
      #1;
      chk("R9 after edge", cell_out, fspec(k[5:0], k[7:6], 1'b1, 1'b1));
      pl = k[5:0];
      pe = k[7:6];
    end

    // Synchronous reset
    @(negedge clk);
    lit_in = 6'b000011; ext_in = 2'b00;
    @(posedge clk); #1;
    chk("R4 registered one", cell_out, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    #1;
    chk("R4 reset waits for edge", cell_out, 1'b1);
    @(posedge clk); #1;
    chk("R8 reset clears output", cell_out, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    ext_in = 2'b11;
    #1;
    chk("R8 config cleared", cell_out, 1'b0);
    chk("R8 chain cleared", cfg_sdo, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule